// File: doc/BRIEF.md
# Two-Channel ADPCM Nibble Fetcher

This block steps two independent playback channels through a shared sample ROM and delivers one 4-bit ADPCM code per channel on every sample strobe, ready for an external decoder. A CPU programs each channel through byte writes. It sets an upper address byte for the first sample byte and an upper address byte for the end, then starts or stops playback with a control byte. The second channel's addresses sit in a fixed upper bank of the ROM.

Within a channel, each ROM byte provides two codes: the high nibble first, then the low nibble. The channel address moves on after the low nibble has been used. The ROM's data lines are wired in a scrambled order, and the block restores the original bit order before it splits a byte into nibbles. When both channels need a ROM byte after the same strobe, the first channel reads first and the second channel reads one cycle later. A stopped channel still answers each strobe, with a zero code.

Top module: `adpcm_nibble_fetch`

## Requirements
- R1: A CPU write to the start register of a channel sets that channel's current address offset to data×256 and makes the next code the high nibble.
- R2: A CPU write to the end register of a channel sets that channel's end offset to data×256.
- R3: Channel 1 reads ROM addresses in the range 0x00000–0x0FFFF. Channel 2 reads ROM addresses in the range 0x10000–0x1FFFF, which means its start and end carry a fixed 0x10000 bank offset.
- R4: Each sample_tick gives one code per playing channel: bits [7:4] of the unscrambled byte, then bits [3:0]. The address advances by 1 after the low nibble.
- R5: After a low nibble, the channel stops if the incremented address offset is greater than or equal to the end offset. This includes the case where the end lies below the start, so that exactly one byte plays.
- R6: A control write of 0x00 stops the channel and a control write of 0x01 starts it. A control write of any other value, including 0x02, has no effect. Stopping keeps the address and nibble phase, so a later start resumes where playback stopped.
- R7: A channel that is not playing pulses its valid output with code 0, one cycle after sample_tick.
- R8: The unscrambled byte bits 7..0 are taken from ROM data bits 7,5,3,1,6,4,2,0 in that order.
- R9: Each channel decodes register addresses as follows. Channel 1 uses start 0x4005, end 0x4006 and control 0x401A. Channel 2 uses start 0x6005, end 0x6006 and control 0x601A. Writes to any other address change nothing.
- R10: Channel 1's code is valid one cycle after sample_tick. Channel 2's code is valid one cycle after sample_tick, or two cycles after it when both channels are playing. Each channel gives exactly one valid pulse per tick. Ticks must be at least four cycles apart.
- R11: After reset, both channels are stopped, with start and end offsets of 0 in their own bank and the high nibble next.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_we | input | 1 | CPU byte write strobe |
| cpu_addr | input | 16 | CPU write address |
| cpu_wdata | input | 8 | CPU write data |
| sample_tick | input | 1 | Sample-rate strobe, one cycle wide |
| rom_addr | output | 17 | Sample ROM byte address |
| rom_rdata | input | 8 | Sample ROM data, combinational, scrambled line order |
| nib_valid | output | 2 | Per-channel code valid pulse |
| nib_code | output | 8 | Per-channel 4-bit codes, channel 1 in [3:0] |

## Verification
The hardest state to reach from the ports is contention for the ROM in the same tick with both channels mid-stream, at the moment one of them reaches its end offset. The bench runs both channels over overlapping ranges of different lengths, so the shorter one stops while the other keeps running, and it checks the second channel's one-cycle and two-cycle latency around that change. Stop and restart in the middle of a byte, re-arming the start register in the middle of a byte, and an end offset below the start are each driven between ticks. Each of these is checked against a model of address and phase kept in the bench.

// File: rtl/adpcm_fetch_pkg.sv
package adpcm_fetch_pkg;

    localparam int OFF_W  = 16;
    localparam int BYTE_W = 8;
    localparam int NIB_W  = 4;

    localparam logic [7:0] REG_START  = 8'h05;
    localparam logic [7:0] REG_END    = 8'h06;
    localparam logic [7:0] REG_CTRL   = 8'h1A;
    localparam logic [7:0] PAGE_FIRST = 8'h40;
    localparam int         PAGE_STEP  = 32;

    typedef enum logic [7:0] {
        CMD_STOP = 8'h00,
        CMD_PLAY = 8'h01,
        CMD_ARM  = 8'h02
    } ctrl_cmd_e;

    typedef struct packed {
        logic playing;
        logic high_next;
        logic pending;
    } chan_flags_t;

    // Restore ROM data line order: new[7:0] = raw{7,5,3,1,6,4,2,0}
    function automatic logic [BYTE_W-1:0] rom_unscramble(input logic [BYTE_W-1:0] raw);
        return {raw[7], raw[5], raw[3], raw[1], raw[6], raw[4], raw[2], raw[0]};
    endfunction

    function automatic logic [7:0] chan_page(input int ch);
        return PAGE_FIRST + 8'(ch * PAGE_STEP);
    endfunction

endpackage

// File: rtl/adpcm_fetch_chan.sv
module adpcm_fetch_chan
    import adpcm_fetch_pkg::*;
#(
    parameter int ADDR_W = 17,
    parameter int CH_IDX = 0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cpu_we,
    input  logic [15:0]       cpu_addr,
    input  logic [7:0]        cpu_wdata,
    input  logic              tick,
    output logic              rom_req,
    output logic [ADDR_W-1:0] rom_addr,
    input  logic              rom_grant,
    input  logic [BYTE_W-1:0] rom_byte,
    output logic              out_valid,
    output logic [NIB_W-1:0]  out_code
);
    localparam int               BANK_W = ADDR_W - OFF_W;
    localparam logic [BANK_W-1:0] BANK  = BANK_W'(CH_IDX);
    localparam logic [7:0]        PAGE  = chan_page(CH_IDX);

    logic [OFF_W-1:0] cur_off;
    logic [OFF_W-1:0] end_off;
    logic [OFF_W:0]   nxt_off;
    chan_flags_t      flags;
    logic             wr_start, wr_end, wr_ctrl;

    assign wr_start = cpu_we && (cpu_addr == {PAGE, REG_START});
    assign wr_end   = cpu_we && (cpu_addr == {PAGE, REG_END});
    assign wr_ctrl  = cpu_we && (cpu_addr == {PAGE, REG_CTRL});
    assign nxt_off  = {1'b0, cur_off} + 1'b1;

    assign rom_req  = flags.pending && flags.playing;
    assign rom_addr = {BANK, cur_off};

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_off   <= '0;
            end_off   <= '0;
            flags     <= '{playing: 1'b0, high_next: 1'b1, pending: 1'b0};
            out_valid <= 1'b0;
            out_code  <= '0;
        end else begin
            out_valid <= 1'b0;
            if (flags.pending && !flags.playing) begin
                out_valid     <= 1'b1;
                out_code      <= '0;
                flags.pending <= 1'b0;
            end
            if (rom_grant) begin
                out_valid       <= 1'b1;
                out_code        <= flags.high_next ? rom_byte[7:4] : rom_byte[3:0];
                flags.high_next <= !flags.high_next;
                flags.pending   <= 1'b0;
                if (!flags.high_next) begin
                    cur_off <= nxt_off[OFF_W-1:0];
                    if (nxt_off >= {1'b0, end_off})
                        flags.playing <= 1'b0;
                end
            end
            if (tick)
                flags.pending <= 1'b1;
            if (wr_start) begin
                cur_off         <= {cpu_wdata, 8'h00};
                flags.high_next <= 1'b1;
            end
            if (wr_end)
                end_off <= {cpu_wdata, 8'h00};
            if (wr_ctrl) begin
                if (cpu_wdata == CMD_STOP)
                    flags.playing <= 1'b0;
                else if (cpu_wdata == CMD_PLAY)
                    flags.playing <= 1'b1;
            end
        end
    end

    // R7
    idle_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !$past(flags.playing)) |-> (out_code == '0));

    // R10
    valid_after_pending_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> $past(flags.pending));

    // R6
    stopped_addr_hold_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(!flags.playing) && !$past(wr_start)) |-> $stable(cur_off));

endmodule

// File: rtl/adpcm_rom_arb.sv
module adpcm_rom_arb
    import adpcm_fetch_pkg::*;
#(
    parameter int NUM_CH = 2,
    parameter int ADDR_W = 17
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic [NUM_CH-1:0]        req,
    input  logic [NUM_CH*ADDR_W-1:0] addr_flat,
    output logic [NUM_CH-1:0]        grant,
    output logic [ADDR_W-1:0]        rom_addr
);
    logic found;

    // Fixed priority: lowest channel index reads first
    always_comb begin
        grant    = '0;
        rom_addr = addr_flat[ADDR_W-1:0];
        found    = 1'b0;
        for (int i = 0; i < NUM_CH; i++) begin
            if (req[i] && !found) begin
                grant[i] = 1'b1;
                rom_addr = addr_flat[i*ADDR_W +: ADDR_W];
                found    = 1'b1;
            end
        end
    end

    // R10
    grant_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(grant));

endmodule

// File: rtl/adpcm_nibble_fetch.sv
module adpcm_nibble_fetch
    import adpcm_fetch_pkg::*;
#(
    parameter int NUM_CH = 2,
    parameter int ADDR_W = 17
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    cpu_we,
    input  logic [15:0]             cpu_addr,
    input  logic [7:0]              cpu_wdata,
    input  logic                    sample_tick,
    output logic [ADDR_W-1:0]       rom_addr,
    input  logic [BYTE_W-1:0]       rom_rdata,
    output logic [NUM_CH-1:0]       nib_valid,
    output logic [NUM_CH*NIB_W-1:0] nib_code
);
    localparam int BANK_W = ADDR_W - OFF_W;

    logic [NUM_CH-1:0]        req;
    logic [NUM_CH-1:0]        grant;
    logic [NUM_CH*ADDR_W-1:0] addr_flat;
    logic [BYTE_W-1:0]        rom_byte;

    assign rom_byte = rom_unscramble(rom_rdata);

    for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
        adpcm_fetch_chan #(
            .ADDR_W (ADDR_W),
            .CH_IDX (c)
        ) u_chan (
            .clk       (clk),
            .rst       (rst),
            .cpu_we    (cpu_we),
            .cpu_addr  (cpu_addr),
            .cpu_wdata (cpu_wdata),
            .tick      (sample_tick),
            .rom_req   (req[c]),
            .rom_addr  (addr_flat[c*ADDR_W +: ADDR_W]),
            .rom_grant (grant[c]),
            .rom_byte  (rom_byte),
            .out_valid (nib_valid[c]),
            .out_code  (nib_code[c*NIB_W +: NIB_W])
        );

        // R3
        bank_route_chk: assert property (@(posedge clk) disable iff (rst)
            grant[c] |-> (rom_addr[ADDR_W-1:OFF_W] == BANK_W'(c)));
    end

    adpcm_rom_arb #(
        .NUM_CH (NUM_CH),
        .ADDR_W (ADDR_W)
    ) u_arb (
        .clk       (clk),
        .rst       (rst),
        .req       (req),
        .addr_flat (addr_flat),
        .grant     (grant),
        .rom_addr  (rom_addr)
    );

endmodule

// File: tb/adpcm_nibble_fetch_bench.sv
`timescale 1ns/1ps
module adpcm_nibble_fetch_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cpu_we = 1'b0;
    logic [15:0] cpu_addr = '0;
    logic [7:0]  cpu_wdata = '0;
    logic        sample_tick = 1'b0;
    logic [16:0] rom_addr;
    logic [7:0]  rom_rdata;
    logic [1:0]  nib_valid;
    logic [7:0]  nib_code;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    int m_cur [2];
    int m_end [2];
    bit m_high[2];
    bit m_play[2];

    always #2 clk = ~clk;

    function automatic logic [7:0] rom_model(input logic [16:0] a);
        return 8'((a[7:0] * 29) + (a[15:8] * 7) + (a[16] ? 8'h5A : 8'h00));
    endfunction

    assign rom_rdata = rom_model(rom_addr);

    adpcm_nibble_fetch u_adpcm_nibble_fetch (
        .clk(clk), .rst(rst), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
        .cpu_wdata(cpu_wdata), .sample_tick(sample_tick), .rom_addr(rom_addr),
        .rom_rdata(rom_rdata), .nib_valid(nib_valid), .nib_code(nib_code)
    );

    task automatic chk(input bit ok, input string req, input int got, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
        end
    endtask

    task automatic model_reset();
        for (int c = 0; c < 2; c++) begin
            m_cur[c] = c * 65536; m_end[c] = c * 65536;
            m_high[c] = 1'b1; m_play[c] = 1'b0;
        end
    endtask

    task automatic cpu_write(input logic [15:0] a, input logic [7:0] d);
        int c;
        @(negedge clk);
        cpu_we = 1'b1; cpu_addr = a; cpu_wdata = d;
        @(negedge clk);
        cpu_we = 1'b0;
        c = (a[15:8] == 8'h40) ? 0 : (a[15:8] == 8'h60) ? 1 : -1;
        if (c >= 0) begin
            if (a[7:0] == 8'h05) begin m_cur[c] = c * 65536 + d * 256; m_high[c] = 1'b1; end
            else if (a[7:0] == 8'h06) m_end[c] = c * 65536 + d * 256;
            else if (a[7:0] == 8'h1A) begin
                if (d == 8'h00) m_play[c] = 1'b0;
                else if (d == 8'h01) m_play[c] = 1'b1;
            end
        end
    endtask

    task automatic tick_check(input string tag);
        int exp_code[2], exp_dly[2], got_code[2], got_dly[2], got_cnt[2];
        logic [7:0] raw;
        for (int c = 0; c < 2; c++) begin
            raw = rom_model(17'(m_cur[c]));
            if (!m_play[c]) exp_code[c] = 0;
            else if (m_high[c]) exp_code[c] = {raw[7], raw[5], raw[3], raw[1]};
            else exp_code[c] = {raw[6], raw[4], raw[2], raw[0]};
            exp_dly[c] = (c == 1 && m_play[0] && m_play[1]) ? 2 : 1;
            got_cnt[c] = 0; got_code[c] = -1; got_dly[c] = 0;
        end
        @(negedge clk);
        sample_tick = 1'b1;
        @(negedge clk);
        sample_tick = 1'b0;
        for (int k = 1; k <= 3; k++) begin
            @(negedge clk);
            for (int c = 0; c < 2; c++) begin
                if (nib_valid[c]) begin
                    got_cnt[c]++; got_dly[c] = k; got_code[c] = int'(nib_code[c*4 +: 4]);
                end
            end
        end
        for (int c = 0; c < 2; c++) begin
            chk(got_cnt[c] == 1, "R10 pulse count", got_cnt[c], 1);
            chk(got_dly[c] == exp_dly[c], "R10 latency", got_dly[c], exp_dly[c]);
            chk(got_code[c] == exp_code[c], m_play[c] ? tag : "R7", got_code[c], exp_code[c]);
            if (m_play[c]) begin
                if (m_high[c]) m_high[c] = 1'b0;
                else begin
                    m_high[c] = 1'b1;
                    m_cur[c]++;
                    if (m_cur[c] >= m_end[c]) m_play[c] = 1'b0;
                end
            end
        end
    endtask

    initial begin
        model_reset();
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R11: stopped after reset, offsets zero
        tick_check("R11");
        tick_check("R11");
        cpu_write(16'h401A, 8'h01);
        for (int i = 0; i < 3; i++) tick_check("R11");
        chk(m_play[0] == 1'b0, "R11 model stop", m_play[0], 0);

        // R4 / R1 / R2: channel 1 sweep over one 256-byte page
        cpu_write(16'h4005, 8'h12);
        cpu_write(16'h4006, 8'h13);
        cpu_write(16'h401A, 8'h00);
        cpu_write(16'h401A, 8'h02);
        cpu_write(16'h401A, 8'h01);
        for (int i = 0; i < 512; i++) tick_check("R4");
        // R5: end reached
        for (int i = 0; i < 2; i++) tick_check("R5");

        // R3 / R10: both channels contending; ch1 ends first
        cpu_write(16'h6005, 8'h34);
        cpu_write(16'h6006, 8'h36);
        cpu_write(16'h4005, 8'h50);
        cpu_write(16'h4006, 8'h51);
        cpu_write(16'h401A, 8'h01);
        cpu_write(16'h601A, 8'h01);
        for (int i = 0; i < 1026; i++) tick_check("R3");

        // R6: dummy, stop mid-byte, odd value, resume
        cpu_write(16'h4005, 8'h70);
        cpu_write(16'h4006, 8'h72);
        cpu_write(16'h401A, 8'h01);
        for (int i = 0; i < 5; i++) tick_check("R6");
        cpu_write(16'h401A, 8'h02);
        for (int i = 0; i < 3; i++) tick_check("R6");
        cpu_write(16'h401A, 8'h00);
        for (int i = 0; i < 3; i++) tick_check("R6");
        cpu_write(16'h401A, 8'h55);
        tick_check("R6");
        cpu_write(16'h401A, 8'h01);
        for (int i = 0; i < 4; i++) tick_check("R6");

        // R1: re-arm start mid-byte resets phase
        tick_check("R1");
        cpu_write(16'h4005, 8'h21);
        for (int i = 0; i < 4; i++) tick_check("R1");
        // R2: shorten end while playing
        cpu_write(16'h4006, 8'h21);
        for (int i = 0; i < 4; i++) tick_check("R2");

        // R9: foreign addresses have no effect; channel 2 regs leave ch1 alone
        cpu_write(16'h4005, 8'h40);
        cpu_write(16'h4006, 8'h42);
        cpu_write(16'h401A, 8'h01);
        tick_check("R9");
        cpu_write(16'h4007, 8'h00);
        cpu_write(16'h5005, 8'h99);
        cpu_write(16'h401B, 8'h00);
        cpu_write(16'h6006, 8'h00);
        cpu_write(16'h601A, 8'h00);
        for (int i = 0; i < 4; i++) tick_check("R9");
        cpu_write(16'h401A, 8'h00);

        // R5: end below start plays exactly one byte
        cpu_write(16'h4005, 8'h30);
        cpu_write(16'h4006, 8'h10);
        cpu_write(16'h401A, 8'h01);
        for (int i = 0; i < 3; i++) tick_check("R5");

        // R8: channel 2 alone, full page of unscrambled bytes
        cpu_write(16'h6005, 8'hAB);
        cpu_write(16'h6006, 8'hAC);
        cpu_write(16'h601A, 8'h01);
        for (int i = 0; i < 514; i++) tick_check("R8");

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: got 0x0 expected 0x1");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule